// File: doc/BRIEF.md
# Modem handshake control and status unit

This unit looks after the modem handshake lines of a serial port. Software writes a control byte. That byte drives four active-low output pins: terminal-ready, request-to-send and two general-purpose auxiliary outputs. The unit samples four active-low input pins: clear-to-send, data-set-ready, ring and carrier-detect. Each input passes through a synchronizer, and the unit shows the input levels in a status byte next to sticky change flags.

Reading the status byte clears the flags. Any flag that is set, once its enable bit allows it, raises an interrupt request. A loopback bit in the control byte parks the output pins in their inactive state and feeds the control bits back into the status logic, so that software can test the path without a cable.

The register port is a plain select / write / address / data interface. Writes take effect on the clock edge. Read data is combinational from the address. The serial data path is not part of this unit.

Top module: `modem_hs_unit`

## Requirements
- R1: After reset all four output pins are high, `irq` is low, and the control, enable and status registers read as 0, provided the input pins are held high.
- R2: The status byte bits 0..3 hold the active-high levels of clear-to-send, data-set-ready, ring and carrier-detect, in that order. Outside loopback each level is the complement of its pin. A pin change appears in these bits after the SYNC_STAGES-flop synchronizer, which is two clock edges by default.
- R3: Status bits 4, 5 and 7 are the change flags for clear-to-send, data-set-ready and carrier-detect. Each flag sets when its level changes in either direction and stays set until the status byte is read.
- R4: Status bit 6 is the ring flag. It sets only when `ring_n` goes from low to high, which is the level going from 1 to 0. The opposite edge leaves it clear.
- R5: A read of the status byte (address 1) returns the value held before the clock edge and clears all four flags at that edge. A flag whose set condition occurs at that same edge ends up set.
- R6: Control byte bits are bit0 terminal-ready, bit1 request-to-send, bit2 aux1, bit3 aux2 and bit4 loopback; bits 7..5 read as 0. Outside loopback, a control bit of 1 drives its pin low and a 0 drives it high.
- R7: With loopback set, all four output pins are held high. The status levels are then taken from the control bits: terminal-ready feeds data-set-ready, request-to-send feeds clear-to-send, aux1 feeds ring and aux2 feeds carrier-detect. A level change caused by entering or leaving loopback sets flags under R3 and R4.
- R8: `irq` is high exactly when the enable register bit 0 (address 2) is 1 and at least one change flag is set.
- R9: The control byte is at address 0, the status byte at address 1 and the enable bit at address 2. Writes to address 1 have no effect, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ring_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| aux1_n | output | 1 | Auxiliary output 1, active low |
| aux2_n | output | 1 | Auxiliary output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A status read and a flag being set can fall on the same clock edge. The bench provokes this by toggling a pin at the falling edge and then placing the status read on the third rising edge after it, the edge at which the synchronized change reaches the flag. It checks two things. The returned byte must already carry the new level while the flag is still clear. A second read must then find the flag set, because set wins over clear.

// File: rtl/mhs_pkg.sv
package mhs_pkg;
   localparam int NUM_LINES = 4;
   localparam int DATA_W    = 8;

   // status line index (bit position of the level in the status byte)
   typedef enum logic [1:0] {
      LN_CTS  = 2'd0,
      LN_DSR  = 2'd1,
      LN_RING = 2'd2,
      LN_DCD  = 2'd3
   } line_e;

   // control byte, bit 0 = terminal ready
   typedef struct packed {
      logic loop;
      logic aux2;
      logic aux1;
      logic rts;
      logic dtr;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mhs_sync.sv
module mhs_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mhs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mhs_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mhs_tracker.sv
module mhs_tracker #(
   parameter int NUM_LINES  = 4,
   parameter int TRAIL_LINE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lvl,
   input  logic                 clr,
   output logic [NUM_LINES-1:0] flags
);
   if (TRAIL_LINE < 0 || TRAIL_LINE >= NUM_LINES) begin : g_bad_trail
      $error("mhs_tracker: TRAIL_LINE out of range");
   end

   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] flag_q;
   logic [NUM_LINES-1:0] hit;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (i == TRAIL_LINE) begin : g_trailing
         // level falls 1->0 when the active-low pin rises
         assign hit[i] = prev_q[i] & ~lvl[i];

         // R4: ring flag rises only after a falling level
         a_r4_trailing_only: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> ($past(prev_q[i]) && !prev_q[i]));
      end else begin : g_any_edge
         assign hit[i] = prev_q[i] ^ lvl[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            flag_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= lvl[i];
            flag_q[i] <= (flag_q[i] & ~clr) | hit[i];
         end
      end

      // R3: a flag holds until a status read
      a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr) |=> flag_q[i]);
   end

   assign flags = flag_q;

   // R5: a read with no new event leaves every flag clear
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (hit == '0)) |=> (flag_q == '0));
endmodule

// File: rtl/mhs_regs.sv
module mhs_regs
   import mhs_pkg::*;
#(
   parameter int              ADDR_W    = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 1,
   parameter logic [ADDR_W-1:0] IE_ADDR   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] status,
   output ctrl_t             ctrl,
   output logic              irq_en,
   output logic              stat_rd
);
   if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR == IE_ADDR || STAT_ADDR == IE_ADDR) begin : g_bad_map
      $error("mhs_regs: register addresses must differ");
   end
   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("mhs_regs: control byte wider than data bus");
   end

   localparam int PAD_W = DATA_W - CTRL_W;

   ctrl_t ctrl_q;
   logic  ie_q;
   logic  wr_ctrl, wr_ie;

   assign wr_ctrl = reg_sel & reg_wr & (reg_addr == CTRL_ADDR);
   assign wr_ie   = reg_sel & reg_wr & (reg_addr == IE_ADDR);
   assign stat_rd = reg_sel & ~reg_wr & (reg_addr == STAT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ie_q   <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_ie)   ie_q   <= reg_wdata[0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CTRL_ADDR)      reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
      else if (reg_addr == STAT_ADDR) reg_rdata = status;
      else if (reg_addr == IE_ADDR)   reg_rdata = {{(DATA_W-1){1'b0}}, ie_q};
   end

   assign ctrl   = ctrl_q;
   assign irq_en = ie_q;

   // R9: a write to the status address touches no stored register
   a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_wr && reg_addr == STAT_ADDR) |=> ($stable(ctrl_q) && $stable(ie_q)));
endmodule

// File: rtl/modem_hs_unit.sv
module modem_hs_unit
   import mhs_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ring_n,
   input  logic              dcd_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              aux1_n,
   output logic              aux2_n,
   output logic              irq
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("modem_hs_unit: ADDR_W must be at least 2");
   end

   logic [NUM_LINES-1:0] pin_s;
   logic [NUM_LINES-1:0] lvl;
   logic [NUM_LINES-1:0] flags;
   logic [DATA_W-1:0]    status;
   ctrl_t                ctrl;
   logic                 irq_en;
   logic                 stat_rd;

   mhs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES), .RST_VAL('1)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dcd_n, ring_n, dsr_n, cts_n}),
      .q     (pin_s)
   );

   // level source: pins or looped-back control bits
   always_comb begin
      if (ctrl.loop) begin
         lvl[LN_CTS]  = ctrl.rts;
         lvl[LN_DSR]  = ctrl.dtr;
         lvl[LN_RING] = ctrl.aux1;
         lvl[LN_DCD]  = ctrl.aux2;
      end else begin
         lvl = ~pin_s;
      end
   end

   mhs_tracker #(.NUM_LINES(NUM_LINES), .TRAIL_LINE(int'(LN_RING))) i_track (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .clr   (stat_rd),
      .flags (flags)
   );

   assign status = {flags[LN_DCD], flags[LN_RING], flags[LN_DSR], flags[LN_CTS], lvl};

   mhs_regs #(.ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .status    (status),
      .ctrl      (ctrl),
      .irq_en    (irq_en),
      .stat_rd   (stat_rd)
   );

   assign dtr_n  = ctrl.loop | ~ctrl.dtr;
   assign rts_n  = ctrl.loop | ~ctrl.rts;
   assign aux1_n = ctrl.loop | ~ctrl.aux1;
   assign aux2_n = ctrl.loop | ~ctrl.aux2;
   assign irq    = irq_en & (|flags);

   // R8: a request implies a stored flag
   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));

   // R1: the first cycle out of reset has no request
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/test_modem_hs_unit.sv
module test_modem_hs_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ring_n = 1'b1, dcd_n = 1'b1;
   logic       dtr_n, rts_n, aux1_n, aux2_n, irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // model state
   logic [4:0] m_ctrl = '0;
   logic       m_ie = 1'b0;
   logic [3:0] m_lvl = '0;
   logic [3:0] m_flag = '0;  // index 0 cts, 1 dsr, 2 ring, 3 dcd

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_hs_unit i_modem_hs_unit (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cts_n(cts_n), .dsr_n(dsr_n), .ring_n(ring_n), .dcd_n(dcd_n),
      .dtr_n(dtr_n), .rts_n(rts_n), .aux1_n(aux1_n), .aux2_n(aux2_n), .irq(irq));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] calc_lvl(input logic [4:0] c, input logic [3:0] pins);
      if (c[4]) return {c[3], c[2], c[0], c[1]};  // dcd<-aux2, ring<-aux1, dsr<-dtr, cts<-rts
      return ~pins;
   endfunction

   function automatic logic [7:0] exp_status();
      return {m_flag, m_lvl};
   endfunction

   function automatic logic [3:0] exp_outs();
      if (m_ctrl[4]) return 4'hF;
      return ~m_ctrl[3:0];  // {aux2,aux1,rts,dtr}
   endfunction

   task automatic model_settle();
      logic [3:0] nl;
      nl = calc_lvl(m_ctrl, {dcd_n, ring_n, dsr_n, cts_n});
      m_flag[0] = m_flag[0] | (nl[0] ^ m_lvl[0]);
      m_flag[1] = m_flag[1] | (nl[1] ^ m_lvl[1]);
      m_flag[2] = m_flag[2] | (m_lvl[2] & ~nl[2]);
      m_flag[3] = m_flag[3] | (nl[3] ^ m_lvl[3]);
      m_lvl = nl;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
      model_settle();
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #(CLK_PERIOD/4);
      d = reg_rdata;
      @(negedge clk);
      reg_sel = 1'b0;
   endtask

   task automatic read_status(input string req);
      logic [7:0] d;
      bus_read(2'd1, d);
      check(req, d, exp_status());
      m_flag = '0;
   endtask

   task automatic check_pins(input string req);
      check(req, {4'h0, aux2_n, aux1_n, rts_n, dtr_n}, {4'h0, exp_outs()});
      check("R8 irq", {7'h0, irq}, {7'h0, m_ie & (|m_flag)});
   endtask

   task automatic set_pins(input logic [3:0] p);  // {dcd,ring,dsr,cts}
      @(negedge clk);
      {dcd_n, ring_n, dsr_n, cts_n} = p;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_pins("R1 pins after reset");
      bus_read(2'd0, d); check("R1 ctrl reset", d, 8'h00);
      bus_read(2'd2, d); check("R1 ie reset", d, 8'h00);
      read_status("R1 status reset");

      // R2/R3 single-line changes
      set_pins(4'b1110); settle();           // cts active
      read_status("R2 R3 cts change");
      read_status("R5 cleared after read");
      set_pins(4'b1010); settle();           // dsr active too
      set_pins(4'b1011); settle();           // cts back
      read_status("R3 dsr and cts sticky");
      set_pins(4'b0011); settle();           // dcd active
      read_status("R3 dcd change");

      // R4 ring edges
      set_pins(4'b0001); settle();           // ring_n falls: leading edge
      read_status("R4 leading edge no flag");
      set_pins(4'b0011); settle();           // ring_n rises: trailing edge
      read_status("R4 trailing edge sets flag");

      // R8 interrupt gating
      set_pins(4'b1011); settle();
      check_pins("R8 flag without enable");
      bus_write(2'd2, 8'h01); m_ie = 1'b1;
      check_pins("R8 flag with enable");
      read_status("R8 clear");
      check_pins("R8 after clear");

      // R5 read and set on the same edge
      @(negedge clk);
      cts_n = ~cts_n;                        // N0
      @(negedge clk);                        // N1; read spans third edge
      bus_read(2'd1, d);
      check("R5 same-edge read returns old flags", d, {4'b0000, calc_lvl(m_ctrl, {dcd_n, ring_n, dsr_n, cts_n})});
      m_flag = '0;
      settle();
      read_status("R5 set wins over clear");

      // R6 control outputs
      bus_write(2'd0, 8'h05); m_ctrl = 5'h05; settle();
      check_pins("R6 dtr and aux1 driven");
      bus_read(2'd0, d); check("R6 ctrl readback", d, 8'h05);
      bus_write(2'd0, 8'hEA); m_ctrl = 5'h0A; settle();
      check_pins("R6 rts and aux2 driven");
      bus_read(2'd0, d); check("R6 upper bits read zero", d, 8'h0A);

      // R7 loopback
      read_status("R7 pre");
      bus_write(2'd0, 8'h1A); m_ctrl = 5'h1A; settle();
      check_pins("R7 outputs parked");
      read_status("R7 levels from control");
      bus_write(2'd0, 8'h15); m_ctrl = 5'h15; settle();
      read_status("R7 loop mapping change");
      set_pins(4'b0000); settle();
      read_status("R7 pins ignored in loop");
      bus_write(2'd0, 8'h00); m_ctrl = 5'h00; settle();
      read_status("R7 leave loop");

      // R9 map
      bus_write(2'd1, 8'hFF); settle();
      bus_read(2'd0, d); check("R9 stat write ignored ctrl", d, {3'b0, m_ctrl});
      bus_read(2'd2, d); check("R9 stat write ignored ie", d, {7'b0, m_ie});
      read_status("R9 stat write ignored status");
      bus_read(2'd3, d); check("R9 unmapped reads zero", d, 8'h00);

      // random mix
      for (int k = 0; k < 400; k++) begin
         int act;
         act = $urandom_range(0, 4);
         case (act)
            0, 1: begin set_pins(4'($urandom)); settle(); end
            2: begin
               logic [7:0] v;
               v = 8'($urandom);
               bus_write(2'd0, v); m_ctrl = v[4:0]; settle();
            end
            3: begin
               logic [7:0] v;
               v = 8'($urandom);
               bus_write(2'd2, v); m_ie = v[0]; settle();
            end
            default: read_status("R2 R3 R4 R7 random status");
         endcase
         check_pins("R6 R7 R8 random pins");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule